// File: doc/BRIEF.md
# Frame-Gated Dual Serial Transmitter

This block serialises words on two transmit lanes that share one bit timing. Each lane keeps a holding register, which the processor side fills, and a shift register, which drives that lane's serial output, most significant bit first. The block runs on the system clock. A one-cycle `bit_tick` strobe marks each bit period, and an `fsync` input, sampled together with `bit_tick`, marks the start of a frame. Every frame start also starts a word. After that, a new word starts every `W` bit ticks.

Each lane has its own enable bit. A set enable acts only at the next frame start. A cleared enable lets the word in flight finish, and the lane then releases its output. A mode bit selects synchronous or asynchronous operation. In asynchronous mode the second lane's enable has no effect. In synchronous mode, when the second lane's enable is still clear at a frame start, that lane's pin carries a software-controlled flag bit for the whole frame.

The holding-register write port is a valid/ready stream. `hold_ready` is tied high, so the port never applies back-pressure. A transfer completes in every cycle in which `hold_valid` is high. A new write replaces any holding value that has not yet been sent.

Top module: `txs_dual_tx`

## Requirements
- R1: Each word is `W` bits, sent MSB first, one bit per `bit_tick`. A `bit_tick` with `fsync` high starts a word, and so does the `W`-th tick after the previous word start. From the edge of the word-start tick, the output shows bit `W-1`.
- R2: When an enabled lane's enable is cleared mid-word, the lane finishes the current word. At the next word start its output enable drops.
- R3: While a lane is inactive, its output enable is 0, its pin is driven 0, and its holding data is not sent.
- R4: A holding write to an inactive lane does not load the shift register. That lane's empty flag goes to 0 and stays 0 while the lane is inactive.
- R5: A lane becomes active only at a word start that is also a frame start. An enable set while the lane is inactive waits for the next frame start, even if other word starts occur first.
- R6: A lane's empty flag (`tx_empty[0]` for lane 0, `tx_empty[1]` for lane 1) goes to 1 when its holding register is copied into the shift register at a word start. A holding write clears it. If the write and the copy fall in the same cycle, the shift register takes the old holding value and the flag ends at 0.
- R7: If an enable is cleared and then set again before the current word ends, the lane keeps sending at the next word start with no gap.
- R8: When the mode bit is 0 (asynchronous), lane 1 never becomes active, whatever its enable is.
- R9: In synchronous mode, when lane 1's enable is clear at a frame start, lane 1 drives `sd1_oe`=1 with `sd1` equal to the stored flag bit until the next frame start.
- R10: After a synchronous active-high reset, both enables are clear, both outputs are tri-stated, and `tx_empty` is 2'b11.
- R11: `hold_ready` is always 1. `hold_sel`=0 addresses lane 0 and `hold_sel`=1 addresses lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| fsync | input | 1 | Frame start, sampled with bit_tick |
| hold_valid | input | 1 | Holding-register write valid |
| hold_sel | input | 1 | Lane selector for the write |
| hold_data | input | W | Word to hold |
| hold_ready | output | 1 | Write accepted (always 1) |
| ctl_we | input | 1 | Loads the four control bits below |
| ctl_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| ctl_en0 | input | 1 | Lane 0 enable |
| ctl_en1 | input | 1 | Lane 1 enable |
| ctl_flag | input | 1 | Flag value for lane 1's pin in flag mode |
| sd0 | output | 1 | Lane 0 serial data |
| sd0_oe | output | 1 | Lane 0 output enable |
| sd1 | output | 1 | Lane 1 serial data or flag |
| sd1_oe | output | 1 | Lane 1 output enable |
| tx_empty | output | 2 | Per-lane empty flags |

## Verification
A holding write and a holding-to-shift copy can land in the same cycle. Both act on the lane's holding register and its empty flag. The bench provokes this by raising `hold_valid` in the very cycle of a word-start `bit_tick`. It then requires the bits that follow to carry the old holding value, the empty flag to read 0 right after, and the next word to carry the new value.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef struct packed {
    logic sync;
    logic en0;
    logic en1;
    logic flag;
  } txs_ctl_t;

  localparam int TXS_LANES = 2;
endpackage

// File: rtl/txs_word_timer.sv
module txs_word_timer #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic fsync,
  output logic word_start,
  output logic frame_start
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  assign frame_start = bit_tick & fsync;
  assign word_start  = bit_tick & (fsync | (cnt == LAST));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (word_start)  cnt <= '0;
    else if (bit_tick)    cnt <= cnt + 1'b1;
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !fsync && cnt != LAST) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/txs_lane.sv
module txs_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_tick,
  input  logic         word_start,
  input  logic         frame_start,
  input  logic         en,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic         active,
  output logic         sdo,
  output logic         empty
);
  logic [W-1:0] hold;
  logic [W-1:0] shreg;
  logic         act_nxt;

  // frame start may switch a lane on; any other word start can only keep or drop it
  always_comb begin
    if (frame_start) act_nxt = en;
    else             act_nxt = active & en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      shreg  <= '0;
    end else if (word_start) begin
      active <= act_nxt;
      if (act_nxt) shreg <= hold;
    end else if (bit_tick && active) begin
      shreg <= {shreg[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     hold <= '0;
    else if (wr) hold <= wr_data;
  end

  // a write in the copy cycle leaves fresh data pending, so it wins
  always_ff @(posedge clk) begin
    if (rst)                        empty <= 1'b1;
    else if (wr)                    empty <= 1'b0;
    else if (word_start && act_nxt) empty <= 1'b1;
  end

  assign sdo = active & shreg[W-1];

  p_enable_at_frame_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(frame_start));
  p_stop_on_word_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(word_start));
  p_empty_on_copy_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(empty) |-> $past(word_start));
  p_write_clears_r4: assert property (@(posedge clk) disable iff (rst)
    wr |=> !empty);
  p_idle_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (!active && !word_start) |=> $stable(shreg));
endmodule

// File: rtl/txs_dual_tx.sv
module txs_dual_tx
  import txs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_tick,
  input  logic         fsync,
  input  logic         hold_valid,
  input  logic         hold_sel,
  input  logic [W-1:0] hold_data,
  output logic         hold_ready,
  input  logic         ctl_we,
  input  logic         ctl_sync,
  input  logic         ctl_en0,
  input  logic         ctl_en1,
  input  logic         ctl_flag,
  output logic         sd0,
  output logic         sd0_oe,
  output logic         sd1,
  output logic         sd1_oe,
  output logic [1:0]   tx_empty
);
  txs_ctl_t ctl_q;
  logic     word_start, frame_start;
  logic     flag_mode;
  logic [TXS_LANES-1:0] act, sdo, emp, en_eff, wr;

  assign hold_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_we) ctl_q <= '{sync: ctl_sync, en0: ctl_en0, en1: ctl_en1, flag: ctl_flag};
  end

  assign en_eff[0] = ctl_q.en0;
  assign en_eff[1] = ctl_q.en1 & ctl_q.sync;

  txs_word_timer #(.W(W)) u_timer (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .fsync(fsync),
    .word_start(word_start), .frame_start(frame_start)
  );

  for (genvar g = 0; g < TXS_LANES; g++) begin : g_lane
    assign wr[g] = hold_valid & (hold_sel == 1'(g));
    txs_lane #(.W(W)) u_lane (
      .clk(clk), .rst(rst), .bit_tick(bit_tick),
      .word_start(word_start), .frame_start(frame_start),
      .en(en_eff[g]), .wr(wr[g]), .wr_data(hold_data),
      .active(act[g]), .sdo(sdo[g]), .empty(emp[g])
    );
  end

  // lane 1 pin becomes a flag for a frame in which its enable was clear
  always_ff @(posedge clk) begin
    if (rst)              flag_mode <= 1'b0;
    else if (frame_start) flag_mode <= ctl_q.sync & ~ctl_q.en1;
  end

  assign sd0      = sdo[0];
  assign sd0_oe   = act[0];
  assign sd1      = act[1] ? sdo[1] : (flag_mode & ctl_q.flag);
  assign sd1_oe   = act[1] | flag_mode;
  assign tx_empty = emp;

  p_async_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.sync && !act[1]) |=> !act[1]);
  p_flag_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(flag_mode && act[1]));
  p_flag_at_frame_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_mode) |-> $past(frame_start));
endmodule

// File: tb/sim_txs_dual_tx.sv
module sim_txs_dual_tx;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bit_tick = 0, fsync = 0, hold_valid = 0, hold_sel = 0;
  logic [W-1:0] hold_data = '0;
  logic ctl_we = 0, ctl_sync = 0, ctl_en0 = 0, ctl_en1 = 0, ctl_flag = 0;
  logic hold_ready, sd0, sd0_oe, sd1, sd1_oe;
  logic [1:0] tx_empty;

  int checks = 0, errors = 0;
  logic [1:0] q0[$];
  logic [1:0] q1[$];
  logic tick_seen = 1'b0;

  always #4 clk = ~clk;

  txs_dual_tx #(.W(W)) u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .fsync(fsync),
    .hold_valid(hold_valid), .hold_sel(hold_sel), .hold_data(hold_data),
    .hold_ready(hold_ready), .ctl_we(ctl_we), .ctl_sync(ctl_sync),
    .ctl_en0(ctl_en0), .ctl_en1(ctl_en1), .ctl_flag(ctl_flag),
    .sd0(sd0), .sd0_oe(sd0_oe), .sd1(sd1), .sd1_oe(sd1_oe), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard driver side: one item {oe, data} per bit tick per lane
  task automatic push_word(input int ch, input logic [W-1:0] d);
    for (int i = W - 1; i >= 0; i--)
      if (ch == 0) q0.push_back({1'b1, d[i]}); else q1.push_back({1'b1, d[i]});
  endtask
  task automatic push_fill(input int ch, input logic oe, input logic v, input int n);
    for (int i = 0; i < n; i++)
      if (ch == 0) q0.push_back({oe, v}); else q1.push_back({oe, v});
  endtask

  // monitor: compare at the falling edge after each tick edge
  always @(posedge clk) tick_seen <= bit_tick;
  always @(negedge clk) begin
    if (tick_seen) begin
      if (q0.size() > 0) begin
        logic [1:0] e;
        e = q0.pop_front();
        chk("R1/R2/R3/R5/R7 lane0 oe", {7'd0, sd0_oe}, {7'd0, e[1]});
        if (e[1]) chk("R1 lane0 data", {7'd0, sd0}, {7'd0, e[0]});
      end
      if (q1.size() > 0) begin
        logic [1:0] e;
        e = q1.pop_front();
        chk("R1/R8/R9 lane1 oe", {7'd0, sd1_oe}, {7'd0, e[1]});
        if (e[1]) chk("R1/R9 lane1 data", {7'd0, sd1}, {7'd0, e[0]});
      end
    end
  end

  task automatic tick(input logic fs, input logic w = 0, input logic s = 0,
                      input logic [W-1:0] d = '0);
    @(negedge clk);
    bit_tick = 1; fsync = fs; hold_valid = w; hold_sel = s; hold_data = d;
    @(negedge clk);
    bit_tick = 0; fsync = 0; hold_valid = 0;
    repeat (2) @(negedge clk);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask
  task automatic wr_hold(input logic s, input logic [W-1:0] d);
    @(negedge clk); hold_valid = 1; hold_sel = s; hold_data = d;
    @(negedge clk); hold_valid = 0;
  endtask
  task automatic set_ctl(input logic sy, input logic e0, input logic e1, input logic fl);
    @(negedge clk); ctl_we = 1; ctl_sync = sy; ctl_en0 = e0; ctl_en1 = e1; ctl_flag = fl;
    @(negedge clk); ctl_we = 0;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 oe0", {7'd0, sd0_oe}, 8'd0);
    chk("R10 oe1", {7'd0, sd1_oe}, 8'd0);
    chk("R10 empty", {6'd0, tx_empty}, 8'd3);
    chk("R11 ready", {7'd0, hold_ready}, 8'd1);

    // R4/R3: write while disabled, nothing sent
    wr_hold(1'b0, 8'hA5);
    chk("R4 empty cleared", {6'd0, tx_empty}, 8'd2);
    push_fill(0, 0, 0, 8); push_fill(1, 0, 0, 8);
    ticks(8);
    chk("R4 empty stays", {6'd0, tx_empty}, 8'd2);

    // R5: enable mid-frame waits for frame start
    set_ctl(1, 1, 0, 1);
    push_fill(0, 0, 0, 5); push_fill(1, 0, 0, 5);
    ticks(5);

    // frame word: A5, lane1 flag=1 (R9)
    push_word(0, 8'hA5); push_fill(1, 1, 1, 8);
    tick(1'b1);
    chk("R6 empty set on copy", {7'd0, tx_empty[0]}, 8'd1);
    ticks(2);
    wr_hold(1'b0, 8'h3C);
    chk("R6 empty cleared by write", {7'd0, tx_empty[0]}, 8'd0);
    tick(1'b0);
    set_ctl(1, 0, 0, 1);   // R7: clear ...
    tick(1'b0);
    set_ctl(1, 1, 0, 1);   // ... and re-set in the same word
    ticks(3);

    // R7 continuous word 3C; R2 disable mid-word
    push_word(0, 8'h3C); push_fill(1, 1, 1, 8);
    ticks(2);
    set_ctl(1, 0, 0, 1);
    ticks(6);

    // R2: released; R5: re-set in a later slot waits for frame
    push_fill(0, 0, 0, 8); push_fill(1, 1, 1, 8);
    ticks(3);
    set_ctl(1, 1, 0, 1);
    ticks(5);
    push_fill(0, 0, 0, 8); push_fill(1, 1, 1, 8);
    ticks(8);
    set_ctl(1, 1, 0, 0);

    // frame: 3C again, flag now 0
    push_word(0, 8'h3C); push_fill(1, 1, 0, 8);
    tick(1'b1);
    ticks(7);

    // R6: write in the copy cycle -> old value sent, empty ends 0
    push_word(0, 8'h3C); push_fill(1, 1, 0, 8);
    tick(1'b0, 1'b1, 1'b0, 8'h0F);
    chk("R6 write wins over copy", {7'd0, tx_empty[0]}, 8'd0);
    ticks(7);
    push_word(0, 8'h0F); push_fill(1, 1, 0, 8);
    ticks(8);
    chk("R6 empty after copy of 0F", {7'd0, tx_empty[0]}, 8'd1);

    // R8: asynchronous mode ignores lane 1 enable
    set_ctl(0, 0, 1, 0);
    wr_hold(1'b1, 8'h96);
    chk("R11 lane1 select", {6'd0, tx_empty}, 8'd1);
    push_fill(0, 0, 0, 8); push_fill(1, 0, 0, 8);
    tick(1'b1);
    ticks(7);

    // synchronous again: waits for frame (R5), then sends 96 (R1)
    set_ctl(1, 0, 1, 0);
    push_fill(0, 0, 0, 8); push_fill(1, 0, 0, 8);
    ticks(8);
    push_fill(0, 0, 0, 8); push_word(1, 8'h96);
    tick(1'b1);
    ticks(7);
    chk("R6 both empty at end", {6'd0, tx_empty}, 8'd3);
    chk("R1 scoreboard drained", 8'(q0.size() + q1.size()), 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule